// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This block holds the data-hazard decisions for an in-order five-stage integer pipeline with fetch, decode, execute, memory and write-back stages. It compares the register numbers that instructions in decode and execute read with the destination numbers held in the execute/memory and memory/write-back latches. From these comparisons it drives the bypass mux selects for both ALU operands and for the store-data path into the memory stage. It also finds a load whose result is needed by the instruction right behind it, and asks for a single bubble.

The register file is expected to pass a value being written straight through to a read of the same register in the same cycle. With that in place, results only need bypassing to the next two instructions. A load's data appears at the end of the memory stage. A dependent ALU source in the next instruction therefore costs one stall cycle. A store that only needs the loaded value as its data does not stall, because that value is bypassed into the memory stage one cycle later. All outputs are combinational. The clock and reset feed only the embedded checks.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An execute-stage operand select (`fwd_a_o` for rs1, `fwd_b_o` for rs2) is 1 (take the execute/memory result) when that latch has write enable set and a destination equal to the non-zero source number.
- R2: The select is 2 (take the memory/write-back result) when only the memory/write-back latch has write enable set and a destination equal to the non-zero source.
- R3: When both latches match the same source, the select is 1, because the younger execute/memory result wins.
- R4: Source register 0 never produces a non-zero select, a store bypass or a stall, even if a producer writes register 0.
- R5: A producer whose write enable is clear never causes a bypass or a stall. This covers two reads of the same register in a row, which give select 0 and no stall.
- R6: A load in execute (write enable set, non-zero destination) whose destination equals a decode source marked as used raises `pc_hold_o`, `ifid_hold_o` and `idex_bubble_o` together in the same cycle.
- R7: A decode source whose use flag is clear never stalls. A decode store whose only match with the execute load is its rs2 (store data) does not stall.
- R8: `st_fwd_o` is 1 when a store in the memory stage has an rs2 equal to the non-zero destination of a write-enabled memory/write-back latch, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for embedded checks |
| id_rs1_i | input | REG_AW | Decode rs1 number |
| id_rs2_i | input | REG_AW | Decode rs2 number |
| id_rs1_use_i | input | 1 | Decode instruction reads rs1 |
| id_rs2_use_i | input | 1 | Decode instruction reads rs2 |
| id_is_store_i | input | 1 | Decode instruction is a store (rs2 is store data) |
| ex_rs1_i | input | REG_AW | Execute rs1 number |
| ex_rs2_i | input | REG_AW | Execute rs2 number |
| ex_rd_i | input | REG_AW | Execute destination |
| ex_we_i | input | 1 | Execute register-write enable |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_AW | Execute/memory latch destination |
| mem_we_i | input | 1 | Execute/memory latch write enable |
| mem_rs2_i | input | REG_AW | Memory-stage store-data register |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| wb_rd_i | input | REG_AW | Memory/write-back latch destination |
| wb_we_i | input | 1 | Memory/write-back latch write enable |
| fwd_a_o | output | 2 | ALU operand A select: 0 register, 1 exe/mem, 2 mem/wb |
| fwd_b_o | output | 2 | ALU operand B select, same encoding |
| st_fwd_o | output | 1 | Store data taken from memory/write-back latch |
| pc_hold_o | output | 1 | Freeze PC |
| ifid_hold_o | output | 1 | Freeze fetch/decode latch |
| idex_bubble_o | output | 1 | Clear write and memory enables entering execute |

## Verification
The bench builds the block with the default REG_AW of 5. This reaches register 31 at the top of the range as well as register 0, and the tests use both. At that width, the source and destination patterns used by the tests cannot alias. The width still covers a wide destination sweep in the priority and store-bypass cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam logic [1:0] FWD_REG = 2'd0;
  localparam logic [1:0] FWD_EXM = 2'd1;
  localparam logic [1:0] FWD_MWB = 2'd2;
endpackage

// File: rtl/hzd_src_fwd.sv
module hzd_src_fwd
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exm_rd_i,
  input  logic              exm_we_i,
  input  logic [REG_AW-1:0] mwb_rd_i,
  input  logic              mwb_we_i,
  output logic [1:0]        sel_o
);
  logic src_nz, hit_exm, hit_mwb;

  assign src_nz  = |src_i;
  assign hit_exm = src_nz && exm_we_i && (exm_rd_i == src_i);
  assign hit_mwb = src_nz && mwb_we_i && (mwb_rd_i == src_i);

  always_comb begin
    if (hit_exm)      sel_o = FWD_EXM;  // younger result first
    else if (hit_mwb) sel_o = FWD_MWB;
    else              sel_o = FWD_REG;
  end

  // R4: register 0 is never bypassed
  a_r4_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == FWD_REG));
  // R5: disabled producers never bypass
  a_r5_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exm_we_i && !mwb_we_i) |-> (sel_o == FWD_REG));
  // R3: older stage used only when younger does not match
  a_r3_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_MWB) |-> !(exm_we_i && exm_rd_i == src_i));
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs1_use_i,
  input  logic              id_rs2_use_i,
  input  logic              id_is_store_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_is_load_i,
  output logic              stall_o
);
  logic ld_live, dep_rs1, dep_rs2;

  assign ld_live = ex_is_load_i && ex_we_i && (|ex_rd_i);
  assign dep_rs1 = id_rs1_use_i && (id_rs1_i == ex_rd_i);
  // store data is consumed in MEM and bypassed there
  assign dep_rs2 = id_rs2_use_i && !id_is_store_i && (id_rs2_i == ex_rd_i);
  assign stall_o = ld_live && (dep_rs1 || dep_rs2);

  // R6: a stall always traces back to a live load in execute
  a_r6_stall_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_is_load_i && ex_we_i));
  // R7: no used source means no stall
  a_r7_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_rs1_use_i && !id_rs2_use_i) |-> !stall_o);
endmodule

// File: rtl/hzd_store_fwd.sv
module hzd_store_fwd #(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic              mem_is_store_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic              st_fwd_o
);
  assign st_fwd_o = mem_is_store_i && wb_we_i && (|wb_rd_i) && (wb_rd_i == mem_rs2_i);

  // R8: bypass only for a store behind a writing producer
  a_r8_st_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_fwd_o |-> (mem_is_store_i && wb_we_i));
  // R4: register 0 is never store data source
  a_r4_st_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rs2_i == '0) |-> !st_fwd_o);
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs1_use_i,
  input  logic              id_rs2_use_i,
  input  logic              id_is_store_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_is_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic              mem_is_store_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              st_fwd_o,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  logic [NSRC-1:0][1:0]        ex_sel;
  logic                        stall;

  assign ex_src = {ex_rs2_i, ex_rs1_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_src_fwd #(.REG_AW(REG_AW)) u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (ex_src[g]),
      .exm_rd_i (mem_rd_i),
      .exm_we_i (mem_we_i),
      .mwb_rd_i (wb_rd_i),
      .mwb_we_i (wb_we_i),
      .sel_o    (ex_sel[g])
    );
  end

  assign fwd_a_o = ex_sel[0];
  assign fwd_b_o = ex_sel[1];

  hzd_load_use #(.REG_AW(REG_AW)) u_ldu (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .id_rs1_i      (id_rs1_i),
    .id_rs2_i      (id_rs2_i),
    .id_rs1_use_i  (id_rs1_use_i),
    .id_rs2_use_i  (id_rs2_use_i),
    .id_is_store_i (id_is_store_i),
    .ex_rd_i       (ex_rd_i),
    .ex_we_i       (ex_we_i),
    .ex_is_load_i  (ex_is_load_i),
    .stall_o       (stall)
  );

  hzd_store_fwd #(.REG_AW(REG_AW)) u_stf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mem_rs2_i      (mem_rs2_i),
    .mem_is_store_i (mem_is_store_i),
    .wb_rd_i        (wb_rd_i),
    .wb_we_i        (wb_we_i),
    .st_fwd_o       (st_fwd_o)
  );

  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;

  // R1: a matching younger producer always bypasses operand A
  a_r1_exm_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && (|ex_rs1_i) && mem_rd_i == ex_rs1_i) |-> (fwd_a_o == FWD_EXM));
  // R2: the older latch is selected only on its own match
  a_r2_mwb_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o == FWD_MWB) |-> (wb_we_i && wb_rd_i == ex_rs2_i));
  // R4: a load into register 0 never freezes the front end
  a_r4_ld_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0) |-> !pc_hold_o);
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_rs1_use, id_rs2_use, id_is_store, ex_we, ex_is_load;
  logic mem_we, mem_is_store, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, pc_hold, ifid_hold, idex_bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  hazard_fwd_unit #(.REG_AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_rs1_use_i(id_rs1_use),
    .id_rs2_use_i(id_rs2_use), .id_is_store_i(id_is_store),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_we_i(ex_we),
    .ex_is_load_i(ex_is_load), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .mem_rs2_i(mem_rs2), .mem_is_store_i(mem_is_store),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .st_fwd_o(st_fwd),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .idex_bubble_o(idex_bubble)
  );

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; id_rs1_use = 0; id_rs2_use = 0; id_is_store = 0;
    ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_we = 0; ex_is_load = 0;
    mem_rd = 0; mem_we = 0; mem_rs2 = 0; mem_is_store = 0;
    wb_rd = 0; wb_we = 0;
  endtask

  // change inputs just after falling edge, sample one ns later
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stall_bits(string req, int exp);
    chk(req, int'(pc_hold), exp);
    chk(req, int'(ifid_hold), exp);
    chk(req, int'(idex_bubble), exp);
  endtask

  task automatic t_reset();
    idle(); settle();
    chk("R5 reset fwd_a", fwd_a, 0);
    chk("R5 reset fwd_b", fwd_b, 0);
    chk("R8 reset st_fwd", st_fwd, 0);
    stall_bits("R6 reset stall", 0);
  endtask

  task automatic t_r1_exm();
    idle(); ex_rs1 = 5'd7; ex_rs2 = 5'd31; mem_rd = 5'd7; mem_we = 1; settle();
    chk("R1 fwd_a exm", fwd_a, 1);
    chk("R1 fwd_b untouched", fwd_b, 0);
    mem_rd = 5'd31; settle();
    chk("R1 fwd_b exm r31", fwd_b, 1);
    chk("R1 fwd_a no match", fwd_a, 0);
  endtask

  task automatic t_r2_mwb();
    idle(); ex_rs1 = 5'd3; ex_rs2 = 5'd9; wb_rd = 5'd9; wb_we = 1;
    mem_rd = 5'd4; mem_we = 1; settle();
    chk("R2 fwd_b mwb", fwd_b, 2);
    chk("R2 fwd_a none", fwd_a, 0);
  endtask

  task automatic t_r3_prio();
    for (int r = 1; r < 32; r += 5) begin
      idle(); ex_rs1 = AW'(r); ex_rs2 = AW'(r);
      mem_rd = AW'(r); mem_we = 1; wb_rd = AW'(r); wb_we = 1; settle();
      chk("R3 prio a", fwd_a, 1);
      chk("R3 prio b", fwd_b, 1);
    end
  endtask

  task automatic t_r4_zero();
    idle(); mem_we = 1; wb_we = 1; ex_we = 1; ex_is_load = 1;
    id_rs1_use = 1; id_rs2_use = 1; mem_is_store = 1; settle();
    chk("R4 zero fwd_a", fwd_a, 0);
    chk("R4 zero fwd_b", fwd_b, 0);
    chk("R4 zero st_fwd", st_fwd, 0);
    stall_bits("R4 zero stall", 0);
  endtask

  task automatic t_r5_no_we();
    idle(); ex_rs1 = 5'd6; ex_rs2 = 5'd6; mem_rd = 5'd6; wb_rd = 5'd6;
    ex_rd = 5'd8; ex_is_load = 1; id_rs1 = 5'd8; id_rs1_use = 1;
    mem_is_store = 1; mem_rs2 = 5'd6; settle();
    chk("R5 read-read fwd_a", fwd_a, 0);
    chk("R5 read-read fwd_b", fwd_b, 0);
    chk("R5 no we st_fwd", st_fwd, 0);
    stall_bits("R5 no we stall", 0);
  endtask

  task automatic t_r6_stall();
    idle(); ex_rd = 5'd12; ex_we = 1; ex_is_load = 1;
    id_rs2 = 5'd12; id_rs2_use = 1; settle();
    stall_bits("R6 load-use rs2", 1);
    id_rs2_use = 0; id_rs1 = 5'd12; id_rs1_use = 1; settle();
    stall_bits("R6 load-use rs1", 1);
    ex_is_load = 0; settle();
    stall_bits("R6 alu producer no stall", 0);
  endtask

  task automatic t_r7_unused();
    idle(); ex_rd = 5'd20; ex_we = 1; ex_is_load = 1;
    id_rs1 = 5'd20; id_rs2 = 5'd20; settle();
    stall_bits("R7 unused sources", 0);
    id_rs2_use = 1; id_is_store = 1; settle();
    stall_bits("R7 store data no stall", 0);
    id_rs1_use = 1; settle();
    stall_bits("R7 store base stalls", 1);
  endtask

  task automatic t_r8_store();
    idle(); mem_is_store = 1; mem_rs2 = 5'd17; wb_rd = 5'd17; wb_we = 1; settle();
    chk("R8 store bypass", st_fwd, 1);
    mem_is_store = 0; settle();
    chk("R8 not store", st_fwd, 0);
    mem_is_store = 1; wb_rd = 5'd16; settle();
    chk("R8 mismatch", st_fwd, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_r1_exm();
    t_r2_mwb();
    t_r3_prio();
    t_r4_zero();
    t_r5_no_we();
    t_r6_stall();
    t_r7_unused();
    t_r8_store();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule